// File: doc/BRIEF.md
# Threshold FIFO DMA requester

A word-wide FIFO placed between a DMA engine and a serial audio shifter. Each location holds one sample word, whatever the sample width. One side belongs to the host (the DMA engine) and the other to the shifter. In the transmit build (`IS_RX = 0`) the host pushes and the shifter pops. In the receive build (`IS_RX = 1`) the shifter pushes and the host pops.

The block does not ask for service word by word. It raises `dma_req` once there is room for, or data for, a whole burst whose length is a programmed number of words. It drops the request as soon as the host has moved that many words, then decides again. An element mode forces the burst length to one word. The fill level is an output, so software can work out stream latency from it. Two sticky flags record a pop from an empty FIFO and a push into a full one.

Top module: `tdma_fifo`

## Requirements
- R1: After reset, `fill_level` is 0 and `dma_req`, `underrun`, `overrun` and `pop_data` are all 0. `thresh_max` always equals the parameter `MAX_THRESH`.
- R2: Words leave in the order they were accepted. `pop_data` shows the head word in the same cycle as an accepted pop. A push and a pop in one cycle both succeed when the FIFO is neither empty nor full.
- R3: After each clock edge, `fill_level` equals accepted pushes minus accepted pops. It never exceeds `DEPTH`.
- R4: Transmit build: when no burst is open, `dma_req` rises on the edge after the free space (`DEPTH - fill_level`) is at least the effective threshold. It stays low while the free space is below that threshold.
- R5: Receive build: when no burst is open, `dma_req` rises on the edge after `fill_level` is at least the effective threshold.
- R6: While `dma_req` is high it holds until the host has moved effective-threshold words. Host moves are pushes in the transmit build and pops in the receive build. The request falls on the edge of the last move, stays low for at least one cycle, and is then decided again from the new fill level.
- R7: With `elem_mode` = 1 the effective threshold is 1, whatever `thresh` holds.
- R8: The effective threshold is `thresh` clamped. A value of 0 acts as 1, and a value above `MAX_THRESH` acts as `MAX_THRESH`.
- R9: A pop from an empty FIFO returns 0 on `pop_data` and leaves the level unchanged. It sets `underrun`, which stays set until reset.
- R10: A push into a full FIFO is dropped and leaves the stored words unchanged. It sets `overrun`, which stays set until reset. A push together with a pop on a full FIFO is also dropped, while the pop succeeds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_en | input | 1 | Write a word (host in transmit build, shifter in receive build) |
| push_data | input | WIDTH | Word to write |
| pop_en | input | 1 | Read a word (shifter in transmit build, host in receive build) |
| pop_data | output | WIDTH | Head word during an accepted pop, else 0 |
| thresh | input | CW | Programmed burst length in words |
| elem_mode | input | 1 | 1 forces a one-word burst |
| dma_req | output | 1 | Service request to the DMA engine |
| fill_level | output | CW | Number of occupied locations |
| thresh_max | output | CW | Largest threshold honoured |
| underrun | output | 1 | Sticky: pop seen while empty |
| overrun | output | 1 | Sticky: push dropped while full |

## Verification
`pop_data` is combinational, so it is due in the same cycle as `pop_en`. `fill_level`, `underrun` and `overrun` are due one edge after the stimulus. `dma_req` falls on the edge of the final host move, but it rises only one edge after the fill level that satisfies the threshold appears, which is two edges after the push or pop that caused it. The bench drives inputs on falling edges and checks `pop_data` 1 ns later. It checks registered results at the next falling edge. For each request transition it counts the exact number of edges before sampling.

// File: rtl/tdma_pkg.sv
`timescale 1ns/1ps
package tdma_pkg;

  // Burst length actually used: element mode and zero both mean one word,
  // anything beyond the ceiling is cut down to it.
  function automatic int unsigned eff_threshold(int unsigned thr, logic elem,
                                                int unsigned max_thr);
    if (elem || thr == 0) return 1;
    if (thr > max_thr) return max_thr;
    return thr;
  endfunction

  // Circular pointer step for any depth, power of two or not.
  function automatic int unsigned ptr_next(int unsigned p, int unsigned depth);
    return (p + 1 == depth) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/tdma_store.sv
`timescale 1ns/1ps
module tdma_store #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 128,
  localparam int unsigned PW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic [CW-1:0]    level,
  output logic             push_ok,
  output logic             pop_ok
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wr_ptr, rd_ptr;

  assign push_ok = push && (level != CW'(DEPTH));
  assign pop_ok  = pop  && (level != '0);
  assign rdata   = pop_ok ? mem[rd_ptr] : '0;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push_ok) wr_ptr <= PW'(tdma_pkg::ptr_next(32'(wr_ptr), DEPTH));
      if (pop_ok)  rd_ptr <= PW'(tdma_pkg::ptr_next(32'(rd_ptr), DEPTH));
      if (push_ok && !pop_ok)      level <= level + CW'(1);
      else if (pop_ok && !push_ok) level <= level - CW'(1);
    end
  end
endmodule

// File: rtl/tdma_req.sv
`timescale 1ns/1ps
module tdma_req #(
  parameter int unsigned DEPTH      = 128,
  parameter int unsigned MAX_THRESH = 128,
  parameter bit          IS_RX      = 1'b0,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] level,
  input  logic [CW-1:0] thr,
  input  logic          elem,
  input  logic          host_xfer,
  output logic          req,
  output logic [CW-1:0] eff_thr
);
  logic [CW-1:0] burst_cnt;
  logic          enough;
  logic          burst_done;

  assign eff_thr = CW'(tdma_pkg::eff_threshold(32'(thr), elem, MAX_THRESH));

  generate
    if (IS_RX) begin : g_rx
      assign enough = level >= eff_thr;
    end else begin : g_tx
      assign enough = (CW'(DEPTH) - level) >= eff_thr;
    end
  endgenerate

  assign burst_done = host_xfer && ((burst_cnt + CW'(1)) == eff_thr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req       <= 1'b0;
      burst_cnt <= '0;
    end else if (req) begin
      if (burst_done) begin
        req       <= 1'b0;
        burst_cnt <= '0;
      end else if (host_xfer) begin
        burst_cnt <= burst_cnt + CW'(1);
      end
    end else begin
      req       <= enough;
      burst_cnt <= '0;
    end
  end
endmodule

// File: rtl/tdma_flags.sv
`timescale 1ns/1ps
module tdma_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  logic push_ok,
  input  logic pop,
  input  logic pop_ok,
  output logic underrun,
  output logic overrun
);
  logic pop_starved, push_dropped;

  assign pop_starved  = pop  && !pop_ok;
  assign push_dropped = push && !push_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      underrun <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      if (pop_starved)  underrun <= 1'b1;
      if (push_dropped) overrun  <= 1'b1;
    end
  end
endmodule

// File: rtl/tdma_fifo.sv
`timescale 1ns/1ps
module tdma_fifo #(
  parameter int unsigned WIDTH      = 32,
  parameter int unsigned DEPTH      = 128,
  parameter int unsigned MAX_THRESH = 128,
  parameter bit          IS_RX      = 1'b0,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_en,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop_en,
  output logic [WIDTH-1:0] pop_data,
  input  logic [CW-1:0]    thresh,
  input  logic             elem_mode,
  output logic             dma_req,
  output logic [CW-1:0]    fill_level,
  output logic [CW-1:0]    thresh_max,
  output logic             underrun,
  output logic             overrun
);
  logic          push_ok, pop_ok, host_xfer;
  logic [CW-1:0] eff_thr;

  assign thresh_max = CW'(MAX_THRESH);

  generate
    if (IS_RX) begin : g_host_pops
      assign host_xfer = pop_ok;
    end else begin : g_host_pushes
      assign host_xfer = push_ok;
    end
  endgenerate

  tdma_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .push(push_en), .wdata(push_data),
    .pop(pop_en), .rdata(pop_data), .level(fill_level),
    .push_ok(push_ok), .pop_ok(pop_ok)
  );

  tdma_req #(.DEPTH(DEPTH), .MAX_THRESH(MAX_THRESH), .IS_RX(IS_RX)) u_req (
    .clk(clk), .rst_n(rst_n), .level(fill_level), .thr(thresh),
    .elem(elem_mode), .host_xfer(host_xfer), .req(dma_req), .eff_thr(eff_thr)
  );

  tdma_flags u_flags (
    .clk(clk), .rst_n(rst_n), .push(push_en), .push_ok(push_ok),
    .pop(pop_en), .pop_ok(pop_ok), .underrun(underrun), .overrun(overrun)
  );
endmodule

// File: rtl/tdma_fifo_chk.sv
`timescale 1ns/1ps
module tdma_fifo_chk #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 128,
  parameter bit          IS_RX = 1'b0,
  parameter int unsigned CW    = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             push_en,
  input logic             pop_en,
  input logic [WIDTH-1:0] pop_data,
  input logic             dma_req,
  input logic [CW-1:0]    fill_level,
  input logic [CW-1:0]    eff_thr,
  input logic             host_xfer,
  input logic             underrun,
  input logic             overrun
);
  logic room;
  assign room = IS_RX ? (fill_level >= eff_thr)
                      : ((CW'(DEPTH) - fill_level) >= eff_thr);

  assert_level_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_level <= CW'(DEPTH));

  assert_level_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (fill_level == $past(fill_level)) ||
             (fill_level == $past(fill_level) + CW'(1)) ||
             (fill_level + CW'(1) == $past(fill_level)));

  assert_empty_pop_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_en && fill_level == '0) |-> (pop_data == '0));

  assert_underrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> underrun);

  assert_overrun_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  assert_full_push_dropped_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (push_en && !pop_en && fill_level == CW'(DEPTH)) |=>
      (fill_level == CW'(DEPTH)) && overrun);

  assert_req_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && !host_xfer) |=> dma_req);

  assert_req_drop_on_xfer_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dma_req) |-> $past(host_xfer));

  assert_req_needs_room_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_req) |-> $past(room));

  assert_thr_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    eff_thr != '0);
endmodule

bind tdma_fifo tdma_fifo_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH), .IS_RX(IS_RX), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .push_en(push_en), .pop_en(pop_en),
  .pop_data(pop_data), .dma_req(dma_req), .fill_level(fill_level),
  .eff_thr(eff_thr), .host_xfer(host_xfer), .underrun(underrun),
  .overrun(overrun)
);

// File: tb/tdma_fifo_test.sv
`timescale 1ns/1ps
module tdma_fifo_test;
  localparam int W = 16;
  localparam int D = 8;
  localparam int C = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  // transmit instance
  logic t_push = 0, t_pop = 0, t_elem = 0;
  logic [W-1:0] t_wd = '0, t_rd;
  logic [C-1:0] t_thr = '0, t_lvl, t_max;
  logic t_req, t_un, t_ov;
  // receive instance
  logic r_push = 0, r_pop = 0, r_elem = 0;
  logic [W-1:0] r_wd = '0, r_rd;
  logic [C-1:0] r_thr = '0, r_lvl, r_max;
  logic r_req, r_un, r_ov;

  tdma_fifo #(.WIDTH(W), .DEPTH(D), .MAX_THRESH(6), .IS_RX(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .push_en(t_push), .push_data(t_wd),
    .pop_en(t_pop), .pop_data(t_rd), .thresh(t_thr), .elem_mode(t_elem),
    .dma_req(t_req), .fill_level(t_lvl), .thresh_max(t_max),
    .underrun(t_un), .overrun(t_ov));

  tdma_fifo #(.WIDTH(W), .DEPTH(D), .MAX_THRESH(8), .IS_RX(1'b1)) uut_rx (
    .clk(clk), .rst_n(rst_n), .push_en(r_push), .push_data(r_wd),
    .pop_en(r_pop), .pop_data(r_rd), .thresh(r_thr), .elem_mode(r_elem),
    .dma_req(r_req), .fill_level(r_lvl), .thresh_max(r_max),
    .underrun(r_un), .overrun(r_ov));

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // {push, pop, push_data[15:0], expected pop_data[15:0], expected level[3:0]}
  localparam logic [37:0] TBL [10] = '{
    {1'b1, 1'b0, 16'h00A1, 16'h0000, 4'd1},
    {1'b1, 1'b0, 16'h00B2, 16'h0000, 4'd2},
    {1'b1, 1'b1, 16'h00C3, 16'h00A1, 4'd2},
    {1'b0, 1'b1, 16'h0000, 16'h00B2, 4'd1},
    {1'b0, 1'b1, 16'h0000, 16'h00C3, 4'd0},
    {1'b1, 1'b0, 16'h0011, 16'h0000, 4'd1},
    {1'b1, 1'b0, 16'h0022, 16'h0000, 4'd2},
    {1'b1, 1'b1, 16'h0033, 16'h0011, 4'd2},
    {1'b0, 1'b1, 16'h0000, 16'h0022, 4'd1},
    {1'b0, 1'b1, 16'h0000, 16'h0033, 4'd0}
  };

  task automatic do_reset;
    rst_n = 0;
    t_push = 0; t_pop = 0; r_push = 0; r_pop = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic tx_push(input logic [W-1:0] d);
    t_push = 1; t_wd = d;
    @(negedge clk);
    t_push = 0;
  endtask

  task automatic tx_pop_chk(input string tag, input int exp);
    t_pop = 1;
    #1 chk(tag, int'(t_rd), exp);
    @(negedge clk);
    t_pop = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    t_thr = 4; r_thr = 3;
    do_reset();
    // R1 reset state, before any edge after release
    chk("R1 tx level", int'(t_lvl), 0);
    chk("R1 tx req", int'(t_req), 0);
    chk("R1 tx underrun", int'(t_un), 0);
    chk("R1 tx overrun", int'(t_ov), 0);
    chk("R1 tx pop_data", int'(t_rd), 0);
    chk("R1 tx thresh_max", int'(t_max), 6);
    chk("R1 rx req", int'(r_req), 0);
    chk("R1 rx thresh_max", int'(r_max), 8);

    // R2/R3 vector table
    for (int i = 0; i < 10; i++) begin
      t_push = TBL[i][37]; t_pop = TBL[i][36]; t_wd = TBL[i][35:20];
      #1 chk("R2 table pop_data", int'(t_rd), int'(TBL[i][19:4]));
      @(negedge clk);
      chk("R3 table level", int'(t_lvl), int'(TBL[i][3:0]));
    end
    t_push = 0; t_pop = 0;

    // R4/R6 transmit bursts, threshold 4
    do_reset();
    @(negedge clk);
    chk("R4 tx req with free 8", int'(t_req), 1);
    for (int i = 0; i < 4; i++) begin
      tx_push(W'(16'h100 + i));
      chk("R6 tx req during burst", int'(t_req), (i < 3) ? 1 : 0);
    end
    @(negedge clk);
    chk("R6 tx req re-evaluated at free 4", int'(t_req), 1);
    for (int i = 4; i < 8; i++) begin
      tx_push(W'(16'h100 + i));
      chk("R6 tx req second burst", int'(t_req), (i < 7) ? 1 : 0);
    end
    chk("R3 tx level full", int'(t_lvl), 8);
    @(negedge clk);
    chk("R4 tx req low at free 0", int'(t_req), 0);

    // R10 overrun
    tx_push(16'h0EE);
    chk("R10 overrun set", int'(t_ov), 1);
    chk("R10 level after dropped push", int'(t_lvl), 8);
    for (int i = 0; i < 8; i++) tx_pop_chk("R10 contents intact", 16'h100 + i);
    chk("R3 level drained", int'(t_lvl), 0);

    // R9 underrun
    tx_pop_chk("R9 empty pop data", 0);
    chk("R9 underrun set", int'(t_un), 1);
    chk("R9 level unchanged", int'(t_lvl), 0);
    repeat (2) @(negedge clk);
    chk("R9 underrun sticky", int'(t_un), 1);
    chk("R10 overrun sticky", int'(t_ov), 1);

    // R8 clamp above ceiling: 7 acts as 6
    t_thr = 7;
    do_reset();
    @(negedge clk);
    chk("R8 clamped req", int'(t_req), 1);
    for (int i = 0; i < 6; i++) begin
      tx_push(W'(16'h300 + i));
      chk("R8 clamped burst of 6", int'(t_req), (i < 5) ? 1 : 0);
    end
    @(negedge clk);
    chk("R8 free 2 below clamp", int'(t_req), 0);

    // R8 zero acts as 1
    t_thr = 0;
    do_reset();
    @(negedge clk);
    chk("R8 zero thr req", int'(t_req), 1);
    tx_push(16'h0401);
    chk("R8 zero thr one-word burst", int'(t_req), 0);
    @(negedge clk);
    chk("R8 zero thr re-request", int'(t_req), 1);

    // R7 element mode versus threshold mode
    t_thr = 5; t_elem = 0;
    do_reset();
    @(negedge clk);
    tx_push(16'h0501);
    chk("R7 threshold mode keeps req after 1 word", int'(t_req), 1);
    t_elem = 1;
    do_reset();
    @(negedge clk);
    chk("R7 elem req", int'(t_req), 1);
    tx_push(16'h0502);
    chk("R7 elem drop after 1 word", int'(t_req), 0);
    @(negedge clk);
    chk("R7 elem re-request", int'(t_req), 1);
    t_elem = 0;

    // R5 receive, threshold 3
    do_reset();
    @(negedge clk);
    chk("R5 rx req empty", int'(r_req), 0);
    for (int i = 0; i < 3; i++) begin
      r_push = 1; r_wd = W'(16'h200 + i);
      @(negedge clk);
      r_push = 0;
      chk("R5 rx req while filling", int'(r_req), 0);
    end
    @(negedge clk);
    chk("R5 rx req at level 3", int'(r_req), 1);
    for (int i = 0; i < 3; i++) begin
      r_pop = 1;
      #1 chk("R2 rx pop order", int'(r_rd), 16'h200 + i);
      @(negedge clk);
      r_pop = 0;
      chk("R6 rx req during burst", int'(r_req), (i < 2) ? 1 : 0);
    end
    @(negedge clk);
    chk("R5 rx req empty again", int'(r_req), 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule